// File: doc/BRIEF.md
# Two-Wire Bus Condition Generator and Arbiter

This block is the line-level engine of a two-wire serial bus master. A byte sequencer above it issues one command at a time (START, STOP, transmit one bit, receive one bit). The engine turns each command into open-drain activity on the clock and data lines. It never drives a line high. It only pulls a line low through an output enable or lets it go, and it reads the wired-AND level back through two-flop synchronizers. A prescaler derived from the system clock frequency and the target bus rate (100 kbit/s by default) sets the length of each low and high clock phase.

The engine watches the bus for START and STOP conditions made by any master and keeps a busy flag. That flag rises on a START. It falls only after a STOP plus a bus-free interval. The high-phase timer starts only once the clock line is actually seen high, so a slave holding the clock low simply delays the bit. Another master pulling the clock low early ends the high phase at once, which gives clock synchronization. While transmitting a 1, the engine compares the released data line with what it reads back. If it reads a 0 while the clock is high, it gives up both lines and reports arbitration loss.

Top module: `bus_cond_gen`

## Requirements
- R1: After reset both output enables are 0, busBusy is 0, and cmdReady is 1.
- R2: A START command (cmdOp code 0) on a free bus lowers SDA while SCL is high. Any SDA fall while SCL is high pulses startSeen for one cycle.
- R3: busBusy rises after a detected START. After a detected STOP it stays 1 for the bus-free interval (FREE_CYC system cycles, 4.7 us scaled), then clears.
- R4: A WRITE command (cmdOp code 2, bit on cmdBit) sets SDA during the SCL low phase, with sdaOe=1 meaning a 0. The value is stable at the SCL rise.
- R5: A READ command (cmdOp code 3) releases SDA and returns the line level seen during the high phase on rxBit, valid when cmdDone pulses.
- R6: The high-phase count starts only after SCL is seen high. A device holding SCL low stalls the bit with no cmdDone, and the following high phase still lasts at least HALF_CYC cycles.
- R7: If SCL is pulled low by another device during the high phase, the engine ends that phase early and asserts sclOe within 4 cycles.
- R8: While transmitting a 1, reading SDA low with SCL high pulses arbLost, releases both lines in the same cycle, and drops bus ownership without cmdDone.
- R9: A START command (code 0) while owning the bus makes a repeated START with no STOP in between.
- R10: A STOP command (cmdOp code 1) raises SDA while SCL is high, leaving both lines released and ownership dropped.
- R11: cmdReady is 0 while the bus is busy and this engine does not own it, and returns to 1 once the bus is free.
- R12: STOP, WRITE and READ commands issued without bus ownership are ignored: no line is pulled and no cmdDone appears.
- R13: During bit transfers SDA changes only while SCL is low, so no spurious START or STOP appears on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered this cycle |
| cmdOp | input | 2 | Command code: 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmdBit | input | 1 | Bit to transmit for WRITE |
| cmdReady | output | 1 | Engine can accept a command |
| cmdDone | output | 1 | One-cycle pulse when a command completes |
| rxBit | output | 1 | Last received bit |
| arbLost | output | 1 | One-cycle pulse on arbitration loss |
| busBusy | output | 1 | Bus busy flag |
| startSeen | output | 1 | One-cycle pulse on a detected START |
| stopSeen | output | 1 | One-cycle pulse on a detected STOP |
| sclIn | input | 1 | Clock line level read back |
| sdaIn | input | 1 | Data line level read back |
| sclOe | output | 1 | Pull clock line low |
| sdaOe | output | 1 | Pull data line low |

## Verification
Faults here show up directly on the lines. A bad timer or phase state shows as a clock phase that is short, long or never ends within one bit time (about 2·HALF_CYC cycles). A bad data state shows as a wrong bit at the next clock rise, or as a START or STOP inserted in the middle of a bit. A stuck ownership or busy state shows as commands that are wrongly ignored or accepted, or as cmdReady failing to return within the bus-free interval after a STOP. A broken arbitration path shows in the same bit: the lost master either keeps driving or reports completion.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } busOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,   // clock pulled low, data set up
    ST_RISE,  // clock released, waiting to see it high
    ST_HIGH,  // clock high, timed
    ST_HOLD   // start hold: data low, clock high
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrClr;
    logic sclPull;
    logic sdaPull;
  } strobe_t;

  // observed line state from datapath to control
  typedef struct packed {
    logic sclS;
    logic sdaS;
    logic tmrDone;
    logic busy;
  } lineStat_t;
endpackage

// File: rtl/bcg_line_dp.sv
module bcg_line_dp
  import bcg_pkg::*;
#(
  parameter int HALF_CYC = 250,
  parameter int FREE_CYC = 235
) (
  input  logic      clk,
  input  logic      rstN,
  input  strobe_t   strobe,
  input  logic      sclIn,
  input  logic      sdaIn,
  output lineStat_t stat,
  output logic      startDet,
  output logic      stopDet,
  output logic      sclOe,
  output logic      sdaOe
);
  localparam int TW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam int FW = $clog2(FREE_CYC + 1);

  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic [TW-1:0] tmrCnt;
  logic [FW-1:0] freeCnt;
  logic busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign startDet = sclPrev & sclSync[1] & sdaPrev & ~sdaSync[1];
  assign stopDet  = sclPrev & sclSync[1] & ~sdaPrev & sdaSync[1];

  // phase timer: counts up from a clear strobe, saturates at the end
  always_ff @(posedge clk) begin
    if (!rstN || strobe.tmrClr) tmrCnt <= '0;
    else if (tmrCnt != TW'(HALF_CYC - 1)) tmrCnt <= tmrCnt + 1'b1;
  end

  // busy tracker with bus-free hold-off after a stop
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      freeCnt <= '0;
    end else if (startDet) begin
      busy    <= 1'b1;
      freeCnt <= '0;
    end else if (stopDet) begin
      freeCnt <= FW'(FREE_CYC);
    end else if (freeCnt != '0) begin
      freeCnt <= freeCnt - 1'b1;
      if (freeCnt == FW'(1)) busy <= 1'b0;
    end
  end

  assign stat.sclS    = sclSync[1];
  assign stat.sdaS    = sdaSync[1];
  assign stat.tmrDone = !strobe.tmrClr && (tmrCnt == TW'(HALF_CYC - 1));
  assign stat.busy    = busy;
  assign sclOe        = strobe.sclPull;
  assign sdaOe        = strobe.sdaPull;
endmodule

// File: rtl/bcg_seq_ctrl.sv
module bcg_seq_ctrl
  import bcg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  busOp_e    cmdOp,
  input  logic      cmdBit,
  input  lineStat_t stat,
  output logic      cmdReady,
  output logic      cmdDone,
  output logic      rxBit,
  output logic      arbLost,
  output strobe_t   strobe
);
  seqState_e state;
  busOp_e    op;
  logic      bitReg, owner;

  assign cmdReady = (state == ST_IDLE) && (owner || !stat.busy);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      op     <= OP_START;
      bitReg <= 1'b0;
      owner  <= 1'b0;
      cmdDone <= 1'b0;
      arbLost <= 1'b0;
      rxBit  <= 1'b0;
      strobe <= '0;
    end else begin
      cmdDone <= 1'b0;
      arbLost <= 1'b0;
      strobe.tmrClr <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmdValid && cmdReady) begin
          op     <= cmdOp;
          bitReg <= cmdBit;
          if (cmdOp == OP_START && !owner) begin
            state <= ST_RISE;             // lines already high on a free bus
          end else if (owner) begin
            state          <= ST_LOW;
            strobe.sclPull <= 1'b1;
            strobe.tmrClr  <= 1'b1;
            strobe.sdaPull <= (cmdOp == OP_STOP) || (cmdOp == OP_WRITE && !cmdBit);
          end
        end
        ST_LOW: if (stat.tmrDone) begin
          state          <= ST_RISE;
          strobe.sclPull <= 1'b0;
        end
        ST_RISE: if (stat.sclS) begin     // stretched clock waits here
          state         <= ST_HIGH;
          strobe.tmrClr <= 1'b1;
        end
        ST_HIGH: begin
          if (op == OP_WRITE && bitReg && !stat.sdaS) begin
            state          <= ST_IDLE;
            arbLost        <= 1'b1;
            owner          <= 1'b0;
            strobe.sclPull <= 1'b0;
            strobe.sdaPull <= 1'b0;
          end else if (stat.tmrDone || !stat.sclS) begin
            unique case (op)
              OP_START: begin
                state          <= ST_HOLD;
                strobe.sdaPull <= 1'b1;
                strobe.tmrClr  <= 1'b1;
              end
              OP_STOP: begin
                state          <= ST_IDLE;
                strobe.sdaPull <= 1'b0;
                owner          <= 1'b0;
                cmdDone        <= 1'b1;
              end
              default: begin
                state          <= ST_IDLE;
                strobe.sclPull <= 1'b1;
                rxBit          <= stat.sdaS;
                cmdDone        <= 1'b1;
              end
            endcase
          end
        end
        ST_HOLD: if (stat.tmrDone) begin
          state          <= ST_IDLE;
          strobe.sclPull <= 1'b1;
          owner          <= 1'b1;
          cmdDone        <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_cond_gen.sv
module bus_cond_gen
  import bcg_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SCL_HZ      = 100_000,
  parameter int BUS_FREE_NS = 4700
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdBit,
  output logic       cmdReady,
  output logic       cmdDone,
  output logic       rxBit,
  output logic       arbLost,
  output logic       busBusy,
  output logic       startSeen,
  output logic       stopSeen,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe
);
  localparam int HALF_CYC = CLK_HZ / (2 * SCL_HZ);
  localparam int FREE_CYC = (CLK_HZ / 1000) * BUS_FREE_NS / 1_000_000;

  strobe_t   strobe;
  lineStat_t stat;

  bcg_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(busOp_e'(cmdOp)),
    .cmdBit(cmdBit), .stat(stat), .cmdReady(cmdReady), .cmdDone(cmdDone),
    .rxBit(rxBit), .arbLost(arbLost), .strobe(strobe)
  );

  bcg_line_dp #(.HALF_CYC(HALF_CYC), .FREE_CYC(FREE_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sclIn(sclIn), .sdaIn(sdaIn),
    .stat(stat), .startDet(startSeen), .stopDet(stopSeen),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

  assign busBusy = stat.busy;
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker (
  input logic clk,
  input logic rstN,
  input logic sclOe,
  input logic sdaOe,
  input logic busBusy,
  input logic cmdDone,
  input logic arbLost,
  input logic startSeen,
  input logic stopSeen
);
  // R8: losing arbitration releases both lines in the reporting cycle
  a_r8_release_on_loss: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |-> (!sclOe && !sdaOe));

  // R8: a lost transfer never also reports completion
  a_r8_done_or_lost: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdDone, arbLost}));

  // R3: a free bus is never clocked by this engine
  a_r3_no_clock_when_free: assert property (@(posedge clk) disable iff (!rstN)
    !busBusy |-> !sclOe);

  // R3: a detected start makes the bus busy on the next cycle
  a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> busBusy);

  // R2: start and stop cannot be detected together
  a_r2_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(startSeen && stopSeen));
endmodule

bind bus_cond_gen bcg_checker u_chk (
  .clk(clk), .rstN(rstN), .sclOe(sclOe), .sdaOe(sdaOe), .busBusy(busBusy),
  .cmdDone(cmdDone), .arbLost(arbLost), .startSeen(startSeen), .stopSeen(stopSeen)
);

// File: tb/bus_cond_gen_tb.sv
module bus_cond_gen_tb;
  // prescaler scaled down: 2 MHz nominal rate keeps bit times short
  localparam int CLK_HZ = 2_000_000;
  localparam int SCL_HZ = 100_000;
  localparam int HALF   = CLK_HZ / (2 * SCL_HZ);
  localparam int FREE   = (CLK_HZ / 1000) * 4700 / 1_000_000;

  typedef struct {
    bit    isArb;
    bit    chkRx;
    bit    rx;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic cmdBit = 1'b0;
  logic cmdReady, cmdDone, rxBit, arbLost, busBusy, startSeen, stopSeen;
  logic sclOe, sdaOe;
  logic tbSclLow = 1'b0, tbSdaLow = 1'b0;
  logic sclLine, sdaLine;

  assign sclLine = !(sclOe || tbSclLow);
  assign sdaLine = !(sdaOe || tbSdaLow);

  always #10 clk = ~clk;  // 50 MHz

  bus_cond_gen #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBit(cmdBit),
    .cmdReady(cmdReady), .cmdDone(cmdDone), .rxBit(rxBit), .arbLost(arbLost),
    .busBusy(busBusy), .startSeen(startSeen), .stopSeen(stopSeen),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  int checks = 0, failures = 0;
  exp_t expQ[$];
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bus monitor: conditions, sampled bits, phase lengths
  int startCnt = 0, stopCnt = 0, seenStart = 0, seenStop = 0, bitCnt = 0;
  bit busBits[64];
  int highRun = 0, lowRun = 0, lastHigh = 0, lastLow = 0;
  logic prevScl = 1'b1, prevSda = 1'b1;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevScl && sclLine && prevSda && !sdaLine) startCnt++;
      if (prevScl && sclLine && !prevSda && sdaLine) stopCnt++;
      if (!prevScl && sclLine) begin
        busBits[bitCnt % 64] = sdaLine;
        bitCnt++;
        lastLow = lowRun;
        highRun = 0;
      end
      if (prevScl && !sclLine) begin
        lastHigh = highRun;
        lowRun = 0;
      end
      if (sclLine) highRun++; else lowRun++;
      if (startSeen) seenStart++;
      if (stopSeen) seenStop++;
    end
    prevScl = sclLine;
    prevSda = sdaLine;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && (cmdDone || arbLost)) begin
      if (expQ.size() == 0) begin
        check(0, "R12 unexpected completion", 1, 0);
      end else begin
        exp_t it;
        it = expQ.pop_front();
        check(it.isArb == arbLost, {it.tag, " outcome"}, int'(arbLost), int'(it.isArb));
        if (it.chkRx) check(rxBit == it.rx, {it.tag, " rxBit"}, int'(rxBit), int'(it.rx));
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic b);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1;
    cmdOp = op;
    cmdBit = b;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic push(input bit isArb, input bit chkRx, input bit rx, input string tag);
    exp_t it;
    it.isArb = isArb; it.chkRx = chkRx; it.rx = rx; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && expQ.size() != 0; i++) @(negedge clk);
    check(expQ.size() == 0, "drain timeout", expQ.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic doCmd(input logic [1:0] op, input logic b, input bit isArb,
                       input bit chkRx, input bit rx, input string tag);
    push(isArb, chkRx, rx, tag);
    issue(op, b);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s0, p0, b0, cnt;
    bit wbits[5] = '{1, 0, 1, 1, 0};
    repeat (5) @(negedge clk);
    // R1 reset state
    check(!sclOe && !sdaOe, "R1 enables", int'({sclOe, sdaOe}), 0);
    check(!busBusy && cmdReady, "R1 busy/ready", int'({busBusy, cmdReady}), 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R12 commands without ownership are ignored
    issue(2'd2, 1'b0);
    issue(2'd1, 1'b0);
    repeat (60) @(negedge clk);
    check(sclLine && sdaLine && !busBusy, "R12 lines idle", int'({sclLine, sdaLine, busBusy}), 6);

    // R2 start on free bus
    doCmd(2'd0, 1'b0, 0, 0, 0, "R2 start");
    check(startCnt == 1 && seenStart == 1, "R2 start seen", startCnt * 10 + seenStart, 11);
    check(busBusy == 1, "R3 busy after start", int'(busBusy), 1);
    check(sclLine == 0, "R2 clock held low by owner", int'(sclLine), 0);

    // R4 / R13 write pattern
    s0 = startCnt; p0 = stopCnt; b0 = bitCnt;
    foreach (wbits[i]) doCmd(2'd2, wbits[i], 0, 0, 0, "R4 write");
    foreach (wbits[i]) check(busBits[(b0 + i) % 64] == wbits[i], "R4 bit value",
                             int'(busBits[(b0 + i) % 64]), int'(wbits[i]));
    check(startCnt == s0 && stopCnt == p0, "R13 no spurious condition",
          (startCnt - s0) + (stopCnt - p0), 0);
    check(lastHigh >= HALF, "R6 nominal high time", lastHigh, HALF);

    // R5 read both levels
    tbSdaLow = 1'b1;
    doCmd(2'd3, 1'b0, 0, 1, 0, "R5 read 0");
    tbSdaLow = 1'b0;
    doCmd(2'd3, 1'b0, 0, 1, 1, "R5 read 1");

    // R6 clock stretching by a slave
    tbSclLow = 1'b1;
    push(0, 0, 0, "R6 stretched write");
    issue(2'd2, 1'b1);
    repeat (150) @(negedge clk);
    check(expQ.size() == 1 && !sclLine, "R6 bit stalled", expQ.size(), 1);
    tbSclLow = 1'b0;
    drain();
    check(lastLow >= 150, "R6 stretched low", lastLow, 150);
    check(lastHigh >= HALF, "R6 high counted after release", lastHigh, HALF);

    // R7 another master shortens the high phase
    push(0, 0, 0, "R7 sync write");
    issue(2'd2, 1'b0);
    while (!sclLine) @(negedge clk);
    repeat (3) @(negedge clk);
    tbSclLow = 1'b1;
    repeat (5) @(negedge clk);
    check(sclOe == 1 && expQ.size() == 0, "R7 early low", int'(sclOe), 1);
    tbSclLow = 1'b0;
    repeat (2) @(negedge clk);
    check(lastHigh < HALF, "R7 shortened high", lastHigh, 3);

    // R9 repeated start
    s0 = startCnt; p0 = stopCnt;
    doCmd(2'd0, 1'b0, 0, 0, 0, "R9 repeated start");
    check(startCnt == s0 + 1 && stopCnt == p0, "R9 no stop between", stopCnt - p0, 0);

    // R10 stop and R3 bus-free interval
    doCmd(2'd1, 1'b0, 0, 0, 0, "R10 stop");
    check(stopCnt == p0 + 1 && sclLine && sdaLine, "R10 lines released", stopCnt - p0, 1);
    check(busBusy == 1, "R3 busy right after stop", int'(busBusy), 1);
    cnt = 0;
    while (busBusy && cnt < 1000) begin @(negedge clk); cnt++; end
    check(cnt >= FREE - 2 && cnt <= FREE + 2, "R3 bus-free interval", cnt, FREE);

    // R8 arbitration loss, R11 readiness while another master holds the bus
    doCmd(2'd0, 1'b0, 0, 0, 0, "R8 start");
    tbSdaLow = 1'b1;
    doCmd(2'd2, 1'b1, 1, 0, 0, "R8 lost");
    check(!sclOe && !sdaOe, "R8 lines released", int'({sclOe, sdaOe}), 0);
    check(cmdReady == 0 && busBusy, "R11 not ready while busy", int'(cmdReady), 0);
    tbSclLow = 1'b1;
    repeat (3) @(negedge clk);
    tbSclLow = 1'b0;
    repeat (3) @(negedge clk);
    p0 = seenStop;
    tbSdaLow = 1'b0;
    repeat (FREE + 10) @(negedge clk);
    check(seenStop == p0 + 1, "R3 foreign stop seen", seenStop - p0, 1);
    check(!busBusy && cmdReady, "R11 ready after bus free", int'(cmdReady), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule